// File: doc/BRIEF.md
# Pseudo-static RAM access controller

This block sits between a synchronous request port and an asynchronous 128K x 8 pseudo-static RAM. It takes one single-word access at a time over a valid/ready handshake and drives the memory strobes: chip enables, output enable and write strobe. It also drives the address bus and the direction of the shared data bus. Every pulse width and gap is a whole number of system clocks. Each count is derived by ceiling division from a nanosecond figure and a clock-period parameter. The defaults suit the fastest speed grade at 125 MHz.

Each access is one chip-enable pulse. The memory takes the address when the enable goes active, and takes write data when the write strobe goes inactive. After every pulse the enable must stay inactive for a precharge gap. A read-modify-write keeps the enable active through a read phase, a bus turnaround and a write phase. After reset the controller holds the enable inactive for the power-up idle time. It then runs a fixed number of dummy cycles, and only after that does it accept host requests.

A separate refresh scheduler asks for the memory through a request/grant pair. The grant is given only between accesses. While the grant is held, the controller keeps the enable inactive and accepts no host request.

Top module: `psram_ctl`

## Requirements
- R1: While reset is held, both chip enables are inactive (`mem_ce_n`=1, `mem_ce`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_ready`=0 and `ref_gnt`=0.
- R2: After reset the chip enable stays inactive for at least the power-up idle time (12500 clocks by default). Exactly 8 chip-enable pulses with no output enable and no response then follow, after which `init_done` rises. `req_ready` is never high while `init_done` is low.
- R3: `req_op` selects the access: 0 reads, 1 writes, 2 does a read-modify-write, and 3 is handled as a read. A read returns the byte most recently written to that address on `rsp_rdata`.
- R4: Every chip-enable pulse lasts at least `T_CE_NS` (8 clocks by default). Between pulses the enable stays inactive for at least `T_PRE_NS` (5 clocks). Leading edges of enable are at least `T_CYC_NS` (13 clocks) apart.
- R5: `mem_addr` holds steady for the whole time the chip enable is active.
- R6: The write strobe is active only inside a chip-enable pulse. Write data is driven (`mem_dq_oe`=1) when the write strobe goes inactive. The write strobe is inactive again before the chip enable goes inactive.
- R7: A read-modify-write uses one chip-enable pulse. It returns the byte held before the access, and it leaves the new byte stored. Its leading edge is at least `T_RMW_NS` (21 clocks) before the next one.
- R8: `mem_dq_oe` and an active `mem_oe_n` never overlap. The data bus is released for at least one clock before the output enable is asserted.
- R9: `req_ready` is low while an access or its precharge is in progress. With no refresh pending it is high again no more than 14 clocks after an acceptance.
- R10: `ref_gnt` is given only while no access is in progress and wins over a host request that arrives in the same cycle. The chip enable stays inactive while `ref_gnt` is high, and `ref_gnt` drops the cycle after `ref_req` falls.
- R11: With `CE_MODE`=0, `mem_ce` is always the inverse of `mem_ce_n`. `CE_MODE`=1 ties `mem_ce` high and `CE_MODE`=2 ties `mem_ce_n` low, and in each case only the other enable toggles.
- R12: `rsp_valid` is a single-clock pulse, given once per read or read-modify-write and never for a write or a dummy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_op | input | 2 | Access type (0 read, 1 write, 2 read-modify-write, 3 read) |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Byte read from memory |
| ref_req | input | 1 | Refresh scheduler asks for the bus |
| ref_gnt | output | 1 | Bus granted to the refresh scheduler |
| init_done | output | 1 | Power-up sequence finished |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Data received from the memory |

## Verification
A refresh request and a host request can land in the same idle cycle, and the controller must settle which one owns the memory. The bench raises `ref_req` and `req_valid` on the same clock. It checks that `req_ready` stays low, that the grant arrives and that no enable pulse occurs while it is held. It then checks that the held host write completes after release and reads back correctly. It also raises the refresh request in the middle of a read and checks that the grant waits until the pulse and its precharge are over.

// File: rtl/psram_pkg.sv
package psram_pkg;

   localparam logic [1:0] OP_READ  = 2'd0;
   localparam logic [1:0] OP_WRITE = 2'd1;
   localparam logic [1:0] OP_RMW   = 2'd2;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ACT,
      SQ_PRE
   } seq_state_e;

   typedef enum logic [1:0] {
      IN_WAIT,
      IN_DUMMY,
      IN_DONE
   } init_state_e;

   // One set of strobe requests, active high, before pin polarity is applied.
   typedef struct packed {
      logic ce;
      logic oe;
      logic we;
      logic dq_oe;
      logic smp;
   } strobe_t;

   function automatic int cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psram_init_seq.sv
module psram_init_seq
   import psram_pkg::*;
#(
   parameter int INIT_CYC = 12500,
   parameter int DUMMY_N  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seq_idle_i,
   output logic dummy_go_o,
   output logic init_done_o
);

   localparam int WW  = $clog2(INIT_CYC + 1);
   localparam int DCW = $clog2(DUMMY_N + 1);
   localparam logic [WW-1:0]  WAIT_LAST = WW'(INIT_CYC - 1);
   localparam logic [DCW-1:0] DUMMY_ALL = DCW'(DUMMY_N);

   init_state_e    st_q;
   logic [WW-1:0]  wcnt_q;
   logic [DCW-1:0] dcnt_q;

   assign dummy_go_o  = (st_q == IN_DUMMY) && seq_idle_i && (dcnt_q != DUMMY_ALL);
   assign init_done_o = (st_q == IN_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= IN_WAIT;
         wcnt_q <= '0;
         dcnt_q <= '0;
      end else begin
         case (st_q)
            IN_WAIT: begin
               if (wcnt_q == WAIT_LAST) st_q <= IN_DUMMY;
               else                     wcnt_q <= wcnt_q + 1'b1;
            end
            IN_DUMMY: begin
               if (seq_idle_i) begin
                  if (dcnt_q == DUMMY_ALL) st_q <= IN_DONE;
                  else                     dcnt_q <= dcnt_q + 1'b1;
               end
            end
            default: st_q <= IN_DONE;
         endcase
      end
   end

endmodule

// File: rtl/psram_cycle_seq.sv
module psram_cycle_seq
   import psram_pkg::*;
#(
   parameter int AW      = 17,
   parameter int DW      = 8,
   parameter int ACT_LEN = 8,
   parameter int RMW_LEN = 15,
   parameter int PRE_LEN = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          dummy_i,
   input  logic [1:0]    op_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic          idle_o,
   output strobe_t       strb_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o
);

   localparam int CW = $clog2(imax(RMW_LEN, PRE_LEN) + 1);
   localparam logic [CW-1:0] ONE        = CW'(1);
   localparam logic [CW-1:0] ACT_LAST   = CW'(ACT_LEN - 1);
   localparam logic [CW-1:0] WE_LAST    = CW'(ACT_LEN - 2);
   localparam logic [CW-1:0] RMW_LAST   = CW'(RMW_LEN - 1);
   localparam logic [CW-1:0] RMW_WE_END = CW'(RMW_LEN - 2);
   localparam logic [CW-1:0] RMW_WR_BEG = CW'(ACT_LEN + 1);
   localparam logic [CW-1:0] PRE_LAST   = CW'(PRE_LEN - 1);

   seq_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic [1:0]    op_q;
   logic          dummy_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wd_q;
   logic [CW-1:0] act_end;

   assign idle_o  = (state_q == SQ_IDLE);
   assign addr_o  = addr_q;
   assign wdata_o = wd_q;
   assign act_end = (op_q == OP_RMW) ? RMW_LAST : ACT_LAST;

   // Strobe decode per phase of the enable pulse.
   always_comb begin
      strb_o = '0;
      if (state_q == SQ_ACT) begin
         strb_o.ce = 1'b1;
         if (op_q == OP_WRITE) begin
            strb_o.dq_oe = 1'b1;
            strb_o.we    = (cnt_q >= ONE) && (cnt_q <= WE_LAST);
         end else if (op_q == OP_RMW) begin
            strb_o.oe    = (cnt_q >= ONE) && (cnt_q <= ACT_LAST);
            strb_o.smp   = (cnt_q == ACT_LAST);
            strb_o.dq_oe = (cnt_q >= RMW_WR_BEG);
            strb_o.we    = (cnt_q >= RMW_WR_BEG) && (cnt_q <= RMW_WE_END);
         end else begin
            strb_o.oe    = !dummy_q && (cnt_q >= ONE);
            strb_o.smp   = !dummy_q && (cnt_q == ACT_LAST);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         op_q    <= OP_READ;
         dummy_q <= 1'b0;
         addr_q  <= '0;
         wd_q    <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (start_i) begin
                  state_q <= SQ_ACT;
                  cnt_q   <= '0;
                  op_q    <= op_i;
                  dummy_q <= dummy_i;
                  addr_q  <= addr_i;
                  wd_q    <= wdata_i;
               end
            end
            SQ_ACT: begin
               if (cnt_q == act_end) begin
                  state_q <= SQ_PRE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_PRE: begin
               if (cnt_q == PRE_LAST) begin
                  state_q <= SQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/psram_pin_drv.sv
module psram_pin_drv
   import psram_pkg::*;
#(
   parameter int CE_MODE = 0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  strobe_t strb_d,
   output logic    ce_n_o,
   output logic    ce_o,
   output logic    oe_n_o,
   output logic    we_n_o,
   output logic    dq_oe_o,
   output logic    smp_o
);

   strobe_t q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= strb_d;
   end

   assign oe_n_o  = ~q.oe;
   assign we_n_o  = ~q.we;
   assign dq_oe_o = q.dq_oe;
   assign smp_o   = q.smp;

   if (CE_MODE == 1) begin : g_low_only
      assign ce_n_o = ~q.ce;
      assign ce_o   = 1'b1;
   end else if (CE_MODE == 2) begin : g_high_only
      assign ce_n_o = 1'b0;
      assign ce_o   = q.ce;
   end else begin : g_both
      assign ce_n_o = ~q.ce;
      assign ce_o   = q.ce;
   end

endmodule

// File: rtl/psram_ctl.sv
module psram_ctl
   import psram_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int CLK_PS    = 8000,
   parameter int T_CE_NS   = 60,
   parameter int T_PRE_NS  = 40,
   parameter int T_CYC_NS  = 100,
   parameter int T_RMW_NS  = 165,
   parameter int T_AH_NS   = 15,
   parameter int T_INIT_NS = 100000,
   parameter int DUMMY_N   = 8,
   parameter int CE_MODE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              ref_req,
   output logic              ref_gnt,
   output logic              init_done,
   output logic              mem_ce_n,
   output logic              mem_ce,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int N_CE    = cdiv(T_CE_NS * 1000, CLK_PS);
   localparam int N_PRE   = cdiv(T_PRE_NS * 1000, CLK_PS);
   localparam int N_CYC   = cdiv(T_CYC_NS * 1000, CLK_PS);
   localparam int N_RMW   = cdiv(T_RMW_NS * 1000, CLK_PS);
   localparam int N_AH    = cdiv(T_AH_NS * 1000, CLK_PS);
   localparam int N_INIT  = imax(1, cdiv(T_INIT_NS * 1000, CLK_PS));
   // One idle clock always separates precharge from the next pulse.
   localparam int ACT_LEN = imax(imax(N_CE, N_CYC - N_PRE - 1), 3);
   localparam int RMW_LEN = imax(N_RMW - N_PRE - 1, ACT_LEN + 4);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("psram_ctl: address and data widths must be positive");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("psram_ctl: clock period must be positive");
   end
   if (CE_MODE < 0 || CE_MODE > 2) begin : g_bad_mode
      $error("psram_ctl: CE_MODE must be 0, 1 or 2");
   end
   if (DUMMY_N < 1) begin : g_bad_dummy
      $error("psram_ctl: at least one dummy cycle is needed");
   end
   if (N_PRE < 1 || N_PRE + 1 < N_AH) begin : g_bad_hold
      $error("psram_ctl: precharge too short to cover address hold");
   end

   logic          seq_idle;
   logic          dummy_go;
   logic          host_go;
   logic          gnt_q;
   logic          smp;
   strobe_t       strb;
   logic [DATA_W-1:0] rdata_q;
   logic          rsp_q;

   assign req_ready = seq_idle && init_done && !ref_req && !gnt_q;
   assign host_go   = req_valid && req_ready;
   assign ref_gnt   = gnt_q;
   assign rsp_valid = rsp_q;
   assign rsp_rdata = rdata_q;

   psram_init_seq #(
      .INIT_CYC (N_INIT),
      .DUMMY_N  (DUMMY_N)
   ) u_init (
      .clk         (clk),
      .rst_n       (rst_n),
      .seq_idle_i  (seq_idle),
      .dummy_go_o  (dummy_go),
      .init_done_o (init_done)
   );

   psram_cycle_seq #(
      .AW      (ADDR_W),
      .DW      (DATA_W),
      .ACT_LEN (ACT_LEN),
      .RMW_LEN (RMW_LEN),
      .PRE_LEN (N_PRE)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (host_go || dummy_go),
      .dummy_i (dummy_go),
      .op_i    (dummy_go ? OP_READ : req_op),
      .addr_i  (dummy_go ? '0 : req_addr),
      .wdata_i (req_wdata),
      .idle_o  (seq_idle),
      .strb_o  (strb),
      .addr_o  (mem_addr),
      .wdata_o (mem_dq_out)
   );

   psram_pin_drv #(
      .CE_MODE (CE_MODE)
   ) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .strb_d  (strb),
      .ce_n_o  (mem_ce_n),
      .ce_o    (mem_ce),
      .oe_n_o  (mem_oe_n),
      .we_n_o  (mem_we_n),
      .dq_oe_o (mem_dq_oe),
      .smp_o   (smp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q   <= 1'b0;
         rsp_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         if (gnt_q) gnt_q <= ref_req;
         else       gnt_q <= ref_req && seq_idle && init_done;
         rsp_q <= smp;
         if (smp) rdata_q <= mem_dq_in;
      end
   end

endmodule

// File: rtl/psram_ctl_chk.sv
module psram_ctl_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              init_done,
   input logic              ref_gnt,
   input logic              rsp_valid,
   input logic              mem_ce_n,
   input logic              mem_ce,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr
);

   logic ce_act;
   assign ce_act = !mem_ce_n && mem_ce;

   a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   a_r8_release_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> !$past(mem_dq_oe));

   a_r6_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> ce_act);

   a_r6_we_ends_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_act && $past(ce_act)) |-> $past(mem_we_n));

   a_r5_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_act && $past(ce_act)) |-> $stable(mem_addr));

   a_r2_no_ready_early: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> !req_ready);

   a_r10_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ref_gnt |-> !ce_act);

   a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !ce_act);

   a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

bind psram_ctl psram_ctl_chk #(.ADDR_W(17)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .init_done (init_done),
   .ref_gnt   (ref_gnt),
   .rsp_valid (rsp_valid),
   .mem_ce_n  (mem_ce_n),
   .mem_ce    (mem_ce),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_dq_oe (mem_dq_oe),
   .mem_addr  (mem_addr)
);

// File: tb/sim_psram_ctl.sv
module sim_psram_ctl;

   localparam int N_CE    = 8;
   localparam int N_PRE   = 5;
   localparam int N_CYC   = 13;
   localparam int N_RMW   = 21;
   localparam int N_INIT  = 12500;
   localparam int N_DUMMY = 8;
   localparam int NADDR   = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid, req_ready;
   logic [1:0]  req_op;
   logic [16:0] req_addr;
   logic [7:0]  req_wdata;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic        ref_req, ref_gnt, init_done;
   logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [16:0] mem_addr;
   logic [7:0]  mem_dq_out, mem_dq_in;

   always #4 clk = ~clk;

   psram_ctl u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ref_req(ref_req), .ref_gnt(ref_gnt), .init_done(init_done),
      .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [7:0] model_mem [int];
   logic [7:0] rd_byte = 8'hEE;
   logic [16:0] lat_addr = '0;
   logic ce_prev = 1'b0, we_prev = 1'b1, oe_prev = 1'b1, dqoe_prev = 1'b0;
   int pulses = 0, since_rise = 0, idle_run = 0, act_run = 0;
   int last_width = 0, last_cycle = 0, cyc_rst = 0, rsp_cnt = 0;
   logic [7:0] last_rd = '0;
   wire ce_now = !mem_ce_n && mem_ce;

   function automatic logic [7:0] peek(input int a);
      if (model_mem.exists(a)) return model_mem[a];
      return 8'hA5;
   endfunction

   assign mem_dq_in = (ce_now && !mem_oe_n && mem_we_n) ? rd_byte : 8'hEE;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc_rst++;
         since_rise++;
         if (ce_now && !ce_prev) begin
            pulses++;
            lat_addr = mem_addr;
            rd_byte <= peek(int'(mem_addr));
            if (pulses == 1)
               chk(cyc_rst >= N_INIT, "R2 idle before first pulse", cyc_rst, N_INIT);
            else begin
               chk(idle_run >= N_PRE, "R4 precharge", idle_run, N_PRE);
               chk(since_rise >= N_CYC, "R4 cycle", since_rise, N_CYC);
            end
            last_cycle = since_rise;
            since_rise = 0;
            idle_run = 0;
            act_run = 0;
            chk(mem_ce == ~mem_ce_n, "R11 polarity rise", mem_ce, ~mem_ce_n);
         end
         if (ce_now) begin
            act_run++;
            if (mem_addr != lat_addr) chk(1'b0, "R5 address moved", mem_addr, lat_addr);
            if (!we_prev && mem_we_n) begin
               model_mem[int'(lat_addr)] = mem_dq_out;
               chk(mem_dq_oe, "R6 data driven at strobe end", mem_dq_oe, 1);
            end
         end else begin
            idle_run++;
            if (ce_prev) begin
               chk(act_run >= N_CE, "R4 pulse width", act_run, N_CE);
               chk(we_prev && mem_we_n, "R6 strobe order", we_prev, 1);
               chk(mem_ce == ~mem_ce_n, "R11 polarity fall", mem_ce, ~mem_ce_n);
               last_width = act_run;
            end
            if (!mem_we_n) chk(1'b0, "R6 strobe outside enable", mem_we_n, 1);
         end
         if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R8 contention", mem_dq_oe, 0);
         if (oe_prev && !mem_oe_n)
            chk(!dqoe_prev && !mem_dq_oe, "R8 bus released first", dqoe_prev, 0);
         if (ref_gnt && ce_now) chk(1'b0, "R10 enable during grant", ce_now, 0);
         if (req_ready && !init_done) chk(1'b0, "R2 ready before init", req_ready, 0);
         if (rsp_valid) begin
            rsp_cnt++;
            last_rd = rsp_rdata;
         end
         ce_prev = ce_now;
         we_prev = mem_we_n;
         oe_prev = mem_oe_n;
         dqoe_prev = mem_dq_oe;
      end
   end

   // ---------------- helpers ----------------
   function automatic logic [16:0] addr_of(input int i);
      if (i < 17) return 17'(1) << i;
      if (i == 17) return 17'h00000;
      if (i == 18) return 17'h1FFFF;
      return 17'h0AAAA;
   endfunction

   function automatic logic [7:0] data_of(input int i, input int salt);
      return 8'(i * 29 + 7 + salt * 101);
   endfunction

   task automatic issue(input logic [1:0] op, input logic [16:0] a, input logic [7:0] d);
      int w = 0;
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
      while (!req_ready && w < 2000) begin @(negedge clk); w++; end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rsp(input int base, output logic [7:0] v, output bit got);
      got = 1'b0;
      for (int k = 0; k < 100; k++) begin
         if (!got && rsp_cnt > base) begin got = 1'b1; v = last_rd; end
         if (!got) @(negedge clk);
      end
      if (!got) v = 8'h00;
   endtask

   task automatic do_read(input logic [1:0] op, input logic [16:0] a, input logic [7:0] exp,
                          input string req);
      int base;
      logic [7:0] v;
      bit got;
      base = rsp_cnt;
      issue(op, a, 8'h00);
      wait_rsp(base, v, got);
      chk(got && v == exp, req, v, exp);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      for (int c = 0; c < 150000; c++) @(negedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      int t, base, p0, busy;
      logic [7:0] v;
      bit got;
      req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_wdata = '0; ref_req = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(mem_ce_n == 1'b1 && mem_ce == 1'b0, "R1 enables idle", {mem_ce_n, mem_ce}, 2);
      chk(mem_oe_n && mem_we_n, "R1 strobes idle", {mem_oe_n, mem_we_n}, 3);
      chk(!mem_dq_oe, "R1 bus released", mem_dq_oe, 0);
      chk(!req_ready && !ref_gnt, "R1 handshake low", {req_ready, ref_gnt}, 0);
      rst_n = 1'b1;

      // R2 power-up sequence
      t = 0;
      while (!init_done && t < 20000) begin @(negedge clk); t++; end
      chk(init_done, "R2 init finished", init_done, 1);
      chk(t >= N_INIT, "R2 idle window length", t, N_INIT);
      chk(pulses == N_DUMMY, "R2 dummy pulse count", pulses, N_DUMMY);
      chk(rsp_cnt == 0, "R12 no response for dummy cycles", rsp_cnt, 0);

      // R3 sweep: write every address, then read back
      for (int i = 0; i < NADDR; i++) begin
         issue(2'd1, addr_of(i), data_of(i, 0));
         chk(!req_ready, "R9 ready low after accept", req_ready, 0);
      end
      @(negedge clk);
      chk(rsp_cnt == 0, "R12 no response for writes", rsp_cnt, 0);
      for (int i = 0; i < NADDR; i++)
         do_read((i == 5) ? 2'd3 : 2'd0, addr_of(i), data_of(i, 0), "R3 read back");
      chk(rsp_cnt == NADDR, "R12 one response per read", rsp_cnt, NADDR);

      // R9 busy window after one accepted read
      while (!req_ready) @(negedge clk);
      issue(2'd0, addr_of(3), 8'h00);
      busy = 0;
      while (!req_ready && busy < 100) begin @(negedge clk); busy++; end
      chk(busy >= N_CE + N_PRE && busy <= N_CYC + 1, "R9 busy window", busy, N_CYC);

      // R7 read-modify-write
      for (int i = 0; i < 4; i++) begin
         base = rsp_cnt;
         while (!req_ready) @(negedge clk);
         p0 = pulses;
         issue(2'd2, addr_of(i * 4 + 1), data_of(i, 7));
         wait_rsp(base, v, got);
         chk(got && v == data_of(i * 4 + 1, 0), "R7 returns old byte", v, data_of(i * 4 + 1, 0));
         while (!req_ready) @(negedge clk);
         chk(pulses == p0 + 1, "R7 single enable pulse", pulses - p0, 1);
         do_read(2'd0, addr_of(i * 4 + 1), data_of(i, 7), "R7 new byte stored");
         chk(last_cycle >= N_RMW, "R7 cycle length", last_cycle, N_RMW);
      end

      // R10 refresh and host request in the same idle cycle
      while (!req_ready) @(negedge clk);
      p0 = pulses;
      ref_req = 1'b1;
      req_valid = 1'b1; req_op = 2'd1; req_addr = 17'h1234A; req_wdata = 8'h3C;
      #1;
      chk(!req_ready, "R10 refresh wins collision", req_ready, 0);
      @(negedge clk);
      chk(ref_gnt, "R10 grant given", ref_gnt, 1);
      repeat (10) @(negedge clk);
      chk(ref_gnt && pulses == p0, "R10 no pulse while granted", pulses - p0, 0);
      ref_req = 1'b0;
      @(negedge clk);
      chk(!ref_gnt, "R10 grant released", ref_gnt, 0);
      issue(2'd1, 17'h1234A, 8'h3C);
      do_read(2'd0, 17'h1234A, 8'h3C, "R10 held write completes");

      // R10 refresh raised during a read
      while (!req_ready) @(negedge clk);
      base = rsp_cnt;
      issue(2'd0, addr_of(2), 8'h00);
      ref_req = 1'b1;
      t = 0;
      while (!ref_gnt && t < 60) begin @(negedge clk); t++; end
      chk(ref_gnt && t >= N_CE + N_PRE - 1, "R10 grant waits for cycle end", t, N_CE + N_PRE);
      chk(rsp_cnt == base + 1 && last_rd == data_of(2, 0), "R3 read beside refresh", last_rd,
          data_of(2, 0));
      ref_req = 1'b0;
      repeat (3) @(negedge clk);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule